// File: doc/BRIEF.md
# DRAM Power-Down Entry and Exit Sequencer

This block sits between a DRAM command queue and the command and clock-enable outputs of a DDR controller. While the power-down request bit is clear, queued commands pass straight through. When the request bit is set, the block lets any burst still in flight finish. It then issues one precharge-all command to every chip select and waits a programmable row-precharge time. Only after that does it drop clock enable.

While the request stays set, no queued command is accepted. Once the request is cleared and a programmable minimum low time has passed, clock enable is raised again. A configuration bit then picks one of two exit paths. The short self-refresh-style path waits a programmable exit delay. The full re-initialization path holds an init request until an external sequencer answers with init done. After either path, the queue is released.

A request that falls back to 0 before clock enable has dropped does not abort entry. The whole entry sequence still runs, and exit follows at once. The DRAM therefore never sees a partial sequence.

Top module: `dram_pd_seq`

## Requirements
- R1: With the request set, precharge-all is never issued while `burst_active` is high. If `burst_active` stays high for B cycles after the request is sampled, the precharge-all appears B+1 cycles after the request (1 cycle when B is 0).
- R2: Precharge-all is shown as `cmd_valid`=1 with `cmd_code`=4'b0010 and `cmd_cs_n` all zero, for exactly one cycle per entry.
- R3: After the precharge-all cycle, `cke` stays high for max(`t_rp`,1) cycles and then goes low.
- R4: From the cycle the request is seen until exit completes, `q_ready` is 0 and no queued command reaches `cmd_valid`.
- R5: `cke` stays low for at least max(`t_cke_min`,1) cycles, and for as long as the request is held.
- R6: With `sr_exit_en`=1, `cke` rises on exit and `q_ready` returns after max(`t_exit`,1) cycles with `cke` high.
- R7: With `sr_exit_en`=0, `cke` rises on exit and `init_req` is held high until `init_done` is sampled. The queue is released in the cycle that follows.
- R8: `in_pd` is 1 exactly while `cke` is 0.
- R9: A request held for a single cycle still produces precharge-all, a `cke` low period of max(`t_cke_min`,1) cycles, and a normal exit.
- R10: With the request clear and no sequence running, `q_ready`=1, `cmd_valid` follows `q_valid`, and `cmd_code` and `cmd_cs_n` follow `q_cmd` and `q_cs_n` in the same cycle.
- R11: During and after reset, `cke`=1, `in_pd`=0, `init_req`=0, and no command is issued unless one is queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pd_req | input | 1 | Software power-down request |
| sr_exit_en | input | 1 | 1 selects the short exit path, 0 selects full re-initialization |
| t_rp | input | TW | Cycles from precharge-all until clock enable drops |
| t_cke_min | input | TW | Minimum cycles with clock enable low |
| t_exit | input | TW | Exit delay on the short path |
| burst_active | input | 1 | A data burst is still in flight |
| q_valid | input | 1 | Command queue has a command |
| q_cmd | input | CMD_W | Queued command code |
| q_cs_n | input | CS_N | Queued chip selects, active low |
| q_ready | output | 1 | Queue may advance |
| cmd_valid | output | 1 | Command issued this cycle |
| cmd_code | output | CMD_W | Issued command code |
| cmd_cs_n | output | CS_N | Issued chip selects, active low |
| cke | output | 1 | DRAM clock enable |
| in_pd | output | 1 | Device is in power-down |
| init_req | output | 1 | Request for full memory initialization |
| init_done | input | 1 | Initialization finished |

## Verification
Every phase boundary comes from one registered state, so each result is due a whole number of clock edges after its cause. The pass-through outputs and `q_ready` settle in the same cycle. The precharge-all is due B+1 edges after the request. The `cke` fall is due max(`t_rp`,1) edges after precharge-all. The `cke` rise is due max(`t_cke_min`, hold, 1) edges after the fall. Queue release is due max(`t_exit`,1) edges after the rise, or one edge after `init_done`. The bench drives and samples 3 ns after each rising edge. It counts the sampled cycles spent in each phase and compares each count with the formula above.

// File: rtl/dram_pd_seq.sv
module dram_pd_seq #(
  parameter int CS_N = 2,
  parameter int CMD_W = 4,
  parameter int TW = 8,
  parameter logic [CMD_W-1:0] PREA_CODE = CMD_W'(2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pd_req,
  input  logic             sr_exit_en,
  input  logic [TW-1:0]    t_rp,
  input  logic [TW-1:0]    t_cke_min,
  input  logic [TW-1:0]    t_exit,
  input  logic             burst_active,
  input  logic             q_valid,
  input  logic [CMD_W-1:0] q_cmd,
  input  logic [CS_N-1:0]  q_cs_n,
  output logic             q_ready,
  output logic             cmd_valid,
  output logic [CMD_W-1:0] cmd_code,
  output logic [CS_N-1:0]  cmd_cs_n,
  output logic             cke,
  output logic             in_pd,
  output logic             init_req,
  input  logic             init_done
);

  typedef enum logic [2:0] {
    S_IDLE, S_DRAIN, S_PREA, S_TRP, S_PD, S_XWAIT, S_REINIT
  } st_t;

  st_t st;
  logic [TW-1:0] cnt;
  logic cnt_last;

  assign cnt_last = (cnt <= TW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        S_IDLE:
          if (pd_req) st <= burst_active ? S_DRAIN : S_PREA;
        S_DRAIN:
          if (!burst_active) st <= S_PREA;
        S_PREA: begin
          st  <= S_TRP;
          cnt <= t_rp;
        end
        S_TRP:
          if (cnt_last) begin
            st  <= S_PD;
            cnt <= t_cke_min;
          end else cnt <= cnt - TW'(1);
        S_PD:
          if (cnt_last && !pd_req) begin
            if (sr_exit_en) begin
              st  <= S_XWAIT;
              cnt <= t_exit;
            end else st <= S_REINIT;
          end else if (!cnt_last) cnt <= cnt - TW'(1);
        S_XWAIT:
          if (cnt_last) st <= S_IDLE;
          else cnt <= cnt - TW'(1);
        S_REINIT:
          if (init_done) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign q_ready   = (st == S_IDLE) && !pd_req;
  assign cmd_valid = (q_ready && q_valid) || (st == S_PREA);
  assign cmd_code  = (st == S_PREA) ? PREA_CODE : q_cmd;
  assign cmd_cs_n  = (st == S_PREA) ? '0 : q_cs_n;
  assign cke       = (st != S_PD);
  assign in_pd     = (st == S_PD);
  assign init_req  = (st == S_REINIT);

endmodule

// File: rtl/dram_pd_seq_chk.sv
module dram_pd_seq_chk #(
  parameter int CS_N = 2,
  parameter int CMD_W = 4,
  parameter logic [CMD_W-1:0] PREA_CODE = CMD_W'(2)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pd_req,
  input logic             burst_active,
  input logic             q_ready,
  input logic             cmd_valid,
  input logic [CMD_W-1:0] cmd_code,
  input logic [CS_N-1:0]  cmd_cs_n,
  input logic             cke,
  input logic             in_pd,
  input logic             init_req
);
  logic prea_now, prea_seen;
  assign prea_now = cmd_valid && (cmd_code == PREA_CODE) && !q_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) prea_seen <= 1'b0;
    else if (prea_now) prea_seen <= 1'b1;
    else if (!cke) prea_seen <= 1'b0;
  end

  a_r1_no_prea_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
    burst_active |-> !prea_now);
  a_r2_prea_all_cs: assert property (@(posedge clk) disable iff (!rst_n)
    prea_now |-> (cmd_cs_n == '0));
  a_r2_prea_single: assert property (@(posedge clk) disable iff (!rst_n)
    prea_now |=> !prea_now);
  a_r3_cke_after_prea: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && !prea_now && !prea_seen) |=> cke);
  a_r4_no_cmd_in_pd: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> (!cmd_valid && !q_ready));
  a_r4_ready_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
    q_ready |-> (cke && !pd_req));
  a_r7_init_with_cke: assert property (@(posedge clk) disable iff (!rst_n)
    init_req |-> (cke && !q_ready));
  a_r8_status: assert property (@(posedge clk) disable iff (!rst_n)
    in_pd == !cke);
endmodule

bind dram_pd_seq dram_pd_seq_chk #(.CS_N(CS_N), .CMD_W(CMD_W), .PREA_CODE(PREA_CODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .burst_active(burst_active),
  .q_ready(q_ready), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
  .cmd_cs_n(cmd_cs_n), .cke(cke), .in_pd(in_pd), .init_req(init_req)
);

// File: tb/dram_pd_seq_test.sv
module dram_pd_seq_test;
  localparam int CS_N = 2;
  localparam int CMD_W = 4;
  localparam int TW = 8;
  localparam logic [3:0] PREA = 4'b0010;

  logic clk = 0, rst_n = 0, pd_req = 0, sr_exit_en = 1, burst_active = 0;
  logic [TW-1:0] t_rp = 1, t_cke_min = 1, t_exit = 1;
  logic q_valid = 0, init_done = 0;
  logic [CMD_W-1:0] q_cmd = '0;
  logic [CS_N-1:0] q_cs_n = '1;
  logic q_ready, cmd_valid, cke, in_pd, init_req;
  logic [CMD_W-1:0] cmd_code;
  logic [CS_N-1:0] cmd_cs_n;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #5 clk = ~clk;

  dram_pd_seq #(.CS_N(CS_N), .CMD_W(CMD_W), .TW(TW)) uut (.*);

  // {sr_exit, burst cycles, t_rp, t_cke_min, hold, t_exit}
  localparam logic [47:0] VEC [8] = '{
    {8'd1, 8'd0, 8'd3, 8'd4, 8'd1, 8'd2},
    {8'd1, 8'd2, 8'd1, 8'd2, 8'd5, 8'd3},
    {8'd0, 8'd0, 8'd2, 8'd3, 8'd2, 8'd4},
    {8'd0, 8'd3, 8'd0, 8'd0, 8'd1, 8'd0},
    {8'd1, 8'd1, 8'd5, 8'd1, 8'd3, 8'd0},
    {8'd0, 8'd0, 8'd1, 8'd6, 8'd6, 8'd1},
    {8'd1, 8'd4, 8'd2, 8'd2, 8'd2, 8'd5},
    {8'd1, 8'd0, 8'd0, 8'd3, 8'd1, 8'd1}
  };

  function automatic int mx1(int a);
    return (a < 1) ? 1 : a;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #3;
  endtask

  task automatic run_case(int sr, int b, int trp, int tck, int hold, int tx);
    int n, w, lo, ex, leak;
    sr_exit_en = sr[0]; t_rp = TW'(trp); t_cke_min = TW'(tck); t_exit = TW'(tx);
    q_valid = 1; q_cmd = 4'h7; q_cs_n = 2'b01;
    pd_req = 1; burst_active = (b > 0);
    #1;
    check(!q_ready, "R4 ready at request", q_ready, 0);
    n = 0; leak = 0;
    do begin
      step(); n++;
      if (burst_active && n == b) burst_active = 0;
      if (cmd_valid && cmd_code != PREA) leak++;
    end while (!(cmd_valid && cmd_code == PREA) && n < 500);
    check(n == b + 1, "R1 precharge delay", n, b + 1);
    check(cmd_cs_n == '0, "R2 precharge chip selects", cmd_cs_n, 0);
    w = 0;
    step();
    check(!(cmd_valid && cmd_code == PREA), "R2 single precharge", cmd_valid, 0);
    while (cke && w < 500) begin w++; step(); end
    check(w == mx1(trp), "R3 cke high after precharge", w, mx1(trp));
    lo = 0;
    while (!cke && lo < 500) begin
      lo++;
      if (!in_pd) begin check(0, "R8 status low", in_pd, 1); end
      if (cmd_valid || q_ready) leak++;
      if (lo == hold) pd_req = 0;
      step();
    end
    check(lo == mx1(tck > hold ? tck : hold), "R5 cke low time", lo, mx1(tck > hold ? tck : hold));
    check(!in_pd, "R8 status after exit", in_pd, 0);
    ex = 0;
    while (!q_ready && ex < 500) begin
      ex++;
      if (!cke) leak++;
      if (sr == 0) begin
        if (!init_req) check(0, "R7 init request held", init_req, 1);
        if (ex == mx1(tx)) init_done = 1;
      end else if (init_req) check(0, "R6 no init request", init_req, 0);
      step();
      init_done = 0;
    end
    check(ex == mx1(tx), sr ? "R6 short exit time" : "R7 init exit time", ex, mx1(tx));
    check(leak == 0, "R4 queue suspended", leak, 0);
    check(cmd_valid && cmd_code == 4'h7 && cmd_cs_n == 2'b01, "R10 queue resumes", cmd_code, 7);
    q_valid = 0;
    step();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int w, lo;
    #3;
    step();
    // R11 reset state
    check(cke && !in_pd && !init_req && !cmd_valid, "R11 reset outputs", {cke, in_pd, init_req, cmd_valid}, 8);
    step(); rst_n = 1; step();
    check(cke && !in_pd && !init_req && !cmd_valid, "R11 after reset", {cke, in_pd, init_req, cmd_valid}, 8);
    // R10 pass-through
    q_valid = 1; q_cmd = 4'h5; q_cs_n = 2'b10; #1;
    check(q_ready && cmd_valid && cmd_code == 4'h5 && cmd_cs_n == 2'b10, "R10 pass-through", cmd_code, 5);
    q_valid = 0; #1;
    check(!cmd_valid && q_ready, "R10 idle no command", cmd_valid, 0);
    step();

    foreach (VEC[i]) begin
      run_case(int'(VEC[i][47:40]), int'(VEC[i][39:32]), int'(VEC[i][31:24]),
               int'(VEC[i][23:16]), int'(VEC[i][15:8]), int'(VEC[i][7:0]));
    end

    // R9 single-cycle request pulse
    sr_exit_en = 1; t_rp = 2; t_cke_min = 3; t_exit = 1;
    pd_req = 1;
    step();
    pd_req = 0; #1;
    check(cmd_valid && cmd_code == PREA, "R9 precharge after pulse", cmd_code, 2);
    check(!q_ready, "R9 queue held after pulse", q_ready, 0);
    w = 0; step();
    while (cke && w < 100) begin w++; step(); end
    check(w == 2, "R9 cke drop after pulse", w, 2);
    lo = 0;
    while (!cke && lo < 100) begin lo++; step(); end
    check(lo == 3, "R9 cke low after pulse", lo, 3);
    step();
    check(q_ready && cke, "R9 resume after pulse", q_ready, 1);

    // R11 reset mid-sequence
    pd_req = 1; step(); step(); step(); step();
    rst_n = 0; pd_req = 0; step(); #1;
    check(cke && !in_pd && !cmd_valid && !init_req, "R11 reset mid-sequence", cke, 1);
    rst_n = 1; step();
    check(q_ready, "R11 ready after reset", q_ready, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule